// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo audio stream (a bit clock, a word clock that marks the two channel halves, and one serial data line) into a pair of parallel samples. It runs entirely on the bit clock. A 3-bit format code chooses one of six framings: right-justified words of 16, 20 or 24 bits, a left-justified 24-bit word, or I2S framing with 16- or 24-bit words. The two remaining codes are treated as invalid.

The word-clock level that marks the left channel depends on the framing. In the justified framings a high word clock is the left channel. In I2S a low word clock is the left channel. Each completed stereo frame (left half, then right half) produces one output pair. The pair is presented as 24-bit two's-complement values, with shorter words placed in the upper bits, and a single-cycle strobe announces it.

A system integrator feeds the bit clock to `bclk` and holds `fmt_sel` steady while the stream runs. Samples are taken on the cycle the strobe is high. Bringing the samples into another clock domain is left to the surrounding logic.

Top module: `aud_ser_rx`

## Requirements
- R1: `wclk` and `sdata` are sampled on the rising edge of `bclk`; each word arrives most significant bit first, in two's complement.
- R2: Codes 000, 001 and 010 select right-justified words of 16, 20 and 24 bits. The word is the last 16, 20 or 24 bits sampled before the word clock changes level, and `wclk` high marks the left channel.
- R3: Code 011 selects a left-justified 24-bit word. Its MSB is the first bit sampled after the word clock changes level, and `wclk` high marks the left channel.
- R4: Codes 100 and 101 select I2S framing with 16- and 24-bit words. The first bit after a word-clock change is skipped, the word occupies the following 16 or 24 bits, and `wclk` low marks the left channel.
- R5: Left and right are never swapped. The strobe comes in the cycle after the first `bclk` edge on which `wclk` shows the left level (high for codes 000 to 011, low for 100 and 101), following a complete right half.
- R6: Outputs are left-aligned. The word MSB sits at bit 23. A 16-bit word leaves bits 7:0 zero, and a 20-bit word leaves bits 3:0 zero.
- R7: `smp_valid` is high for exactly one `bclk` cycle per stereo frame. `left_smp` and `right_smp` change only together with the strobe (or with an invalid code, see R8).
- R8: Codes 110 and 111 are invalid. From the first `bclk` edge that sees such a code, both sample outputs are zero and no strobe is issued.
- R9: A channel half may be longer than the word, and the two halves may have different lengths, within the word clock's ±2-bit duty tolerance or more. Right-justified framing takes the trailing bits, while left-justified and I2S framing take the leading bits, and the extra bits are ignored.
- R10: Reset (`rst_n` low, asynchronous) clears both samples and the strobe. A channel half already in progress when reset is released is discarded. The first strobe therefore requires a complete left half and a complete right half, each begun by a word-clock change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| wclk | input | 1 | Word clock marking the left and right channel halves |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 3 | Framing code (see R2, R3, R4, R8) |
| left_smp | output | 24 | Left-channel sample, left-aligned two's complement |
| right_smp | output | 24 | Right-channel sample, left-aligned two's complement |
| smp_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |

## Verification
Every valid framing is driven with distinct left and right words: positive, negative, all-ones, and one with only the sign bit set. The filler bits in the unused slots are random, so taking bits from the wrong end of a half, or skipping the I2S delay bit wrongly, shows up as a data mismatch. Distinct left and right values expose a swapped channel polarity. Each framing is also run with halves of exactly the minimum length, with halves longer than the word, and with halves of unequal length. These runs separate end-aligned capture from start-aligned capture. Separate runs cover an invalid code, including a switch from a valid code to an invalid one mid-stream, and reset release in the middle of a half, where a premature strobe would be caught.

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
package aud_ser_pkg;

  localparam int LEN_W = 5;

  typedef enum logic [1:0] {
    ALIGN_RIGHT = 2'd0,
    ALIGN_LEFT  = 2'd1,
    ALIGN_I2S   = 2'd2,
    ALIGN_NONE  = 2'd3
  } align_e;

  typedef struct packed {
    align_e           align;
    logic [LEN_W-1:0] word_len;
    logic [LEN_W-1:0] pad;
    logic             left_hi;
    logic             invalid;
  } fmt_cfg_t;

endpackage

// File: rtl/aud_fmt_decode.sv
`timescale 1ns/1ps
module aud_fmt_decode
  import aud_ser_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic [2:0] fmt_sel,
  output fmt_cfg_t   cfg
);

  localparam logic [LEN_W-1:0] L16 = LEN_W'(16);
  localparam logic [LEN_W-1:0] L20 = LEN_W'(20);
  localparam logic [LEN_W-1:0] L24 = LEN_W'(24);
  localparam logic [LEN_W-1:0] P16 = LEN_W'(SMP_W - 16);
  localparam logic [LEN_W-1:0] P20 = LEN_W'(SMP_W - 20);
  localparam logic [LEN_W-1:0] P24 = LEN_W'(SMP_W - 24);

  always_comb begin
    cfg = '{align: ALIGN_NONE, word_len: '0, pad: '0, left_hi: 1'b1, invalid: 1'b1};
    unique case (fmt_sel)
      3'b000: cfg = '{align: ALIGN_RIGHT, word_len: L16, pad: P16, left_hi: 1'b1, invalid: 1'b0};
      3'b001: cfg = '{align: ALIGN_RIGHT, word_len: L20, pad: P20, left_hi: 1'b1, invalid: 1'b0};
      3'b010: cfg = '{align: ALIGN_RIGHT, word_len: L24, pad: P24, left_hi: 1'b1, invalid: 1'b0};
      3'b011: cfg = '{align: ALIGN_LEFT,  word_len: L24, pad: P24, left_hi: 1'b1, invalid: 1'b0};
      3'b100: cfg = '{align: ALIGN_I2S,   word_len: L16, pad: P16, left_hi: 1'b0, invalid: 1'b0};
      3'b101: cfg = '{align: ALIGN_I2S,   word_len: L24, pad: P24, left_hi: 1'b0, invalid: 1'b0};
      default: cfg = '{align: ALIGN_NONE, word_len: '0, pad: '0, left_hi: 1'b1, invalid: 1'b1};
    endcase
  end

endmodule

// File: rtl/aud_bit_collect.sv
`timescale 1ns/1ps
module aud_bit_collect
  import aud_ser_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wclk,
  input  logic             sdata,
  input  fmt_cfg_t         cfg,
  output logic             done,
  output logic             done_left,
  output logic [SMP_W-1:0] word
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             primed_q, wclk_q, half_ok_q;
  logic [IDX_W-1:0] idx_q, idx_d, len_ext;
  logic [SMP_W-1:0] acc_q, acc_d, base;
  logic             lvl_change, take;

  // next-state: position inside the current channel half and word capture
  always_comb begin
    lvl_change = primed_q && (wclk != wclk_q);
    len_ext    = IDX_W'(cfg.word_len);
    if (lvl_change)            idx_d = '0;
    else if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
    else                       idx_d = idx_q;

    unique case (cfg.align)
      ALIGN_RIGHT: take = 1'b1;
      ALIGN_LEFT:  take = (idx_d < len_ext);
      ALIGN_I2S:   take = (idx_d != '0) && (idx_d <= len_ext);
      default:     take = 1'b0;
    endcase

    base  = lvl_change ? '0 : acc_q;
    acc_d = take ? {base[SMP_W-2:0], sdata} : base;

    done      = lvl_change && half_ok_q;
    done_left = (wclk_q == cfg.left_hi);
    word      = acc_q << cfg.pad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      wclk_q    <= 1'b0;
      half_ok_q <= 1'b0;
      idx_q     <= '0;
      acc_q     <= '0;
    end else begin
      primed_q <= 1'b1;
      wclk_q   <= wclk;
      idx_q    <= idx_d;
      acc_q    <= acc_d;
      if (lvl_change) half_ok_q <= 1'b1;
    end
  end

endmodule

// File: rtl/aud_frame_pair.sv
`timescale 1ns/1ps
module aud_frame_pair #(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             invalid,
  input  logic             done,
  input  logic             done_left,
  input  logic [SMP_W-1:0] word,
  output logic [SMP_W-1:0] left_smp,
  output logic [SMP_W-1:0] right_smp,
  output logic             smp_valid
);

  logic [SMP_W-1:0] hold_q, hold_d, left_q, left_d, right_q, right_d;
  logic             have_q, have_d, valid_q, valid_d;

  always_comb begin
    hold_d  = hold_q;
    have_d  = have_q;
    left_d  = left_q;
    right_d = right_q;
    valid_d = 1'b0;
    if (invalid) begin
      hold_d  = '0;
      have_d  = 1'b0;
      left_d  = '0;
      right_d = '0;
    end else if (done) begin
      if (done_left) begin
        hold_d = word;
        have_d = 1'b1;
      end else begin
        if (have_q) begin
          left_d  = hold_q;
          right_d = word;
          valid_d = 1'b1;
        end
        have_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      have_q  <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
      valid_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      have_q  <= have_d;
      left_q  <= left_d;
      right_q <= right_d;
      valid_q <= valid_d;
    end
  end

  assign left_smp  = left_q;
  assign right_smp = right_q;
  assign smp_valid = valid_q;

endmodule

// File: rtl/aud_ser_rx.sv
`timescale 1ns/1ps
module aud_ser_rx
  import aud_ser_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int IDX_W = 6
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             wclk,
  input  logic             sdata,
  input  logic [2:0]       fmt_sel,
  output logic [SMP_W-1:0] left_smp,
  output logic [SMP_W-1:0] right_smp,
  output logic             smp_valid
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  fmt_cfg_t         cfg;
  logic             done, done_left;
  logic [SMP_W-1:0] word;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  aud_fmt_decode #(.SMP_W(SMP_W)) u_dec (
    .fmt_sel (fmt_sel),
    .cfg     (cfg)
  );

  aud_bit_collect #(.SMP_W(SMP_W), .IDX_W(IDX_W)) u_col (
    .clk       (bclk),
    .rst_n     (rst_int_n),
    .wclk      (wclk),
    .sdata     (sdata),
    .cfg       (cfg),
    .done      (done),
    .done_left (done_left),
    .word      (word)
  );

  aud_frame_pair #(.SMP_W(SMP_W)) u_pair (
    .clk       (bclk),
    .rst_n     (rst_int_n),
    .invalid   (cfg.invalid),
    .done      (done),
    .done_left (done_left),
    .word      (word),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .smp_valid (smp_valid)
  );

endmodule

// File: rtl/aud_ser_rx_chk.sv
`timescale 1ns/1ps
module aud_ser_rx_chk #(
  parameter int SMP_W = 24
) (
  input logic             bclk,
  input logic             rst_n,
  input logic             wclk,
  input logic [2:0]       fmt_sel,
  input logic [SMP_W-1:0] left_smp,
  input logic [SMP_W-1:0] right_smp,
  input logic             smp_valid
);

  p_strobe_single_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  p_hold_between_r7: assert property (@(posedge bclk) disable iff (!rst_n)
    (!smp_valid && $past(fmt_sel[2:1] != 2'b11)) |-> ($stable(left_smp) && $stable(right_smp)));

  p_left_high_edge_r5: assert property (@(posedge bclk) disable iff (!rst_n)
    (smp_valid && $past(fmt_sel[2] == 1'b0)) |-> ($past(wclk) && !$past(wclk, 2)));

  p_left_low_edge_r4: assert property (@(posedge bclk) disable iff (!rst_n)
    (smp_valid && $past(fmt_sel[2:1] == 2'b10)) |-> (!$past(wclk) && $past(wclk, 2)));

  p_invalid_quiet_r8: assert property (@(posedge bclk) disable iff (!rst_n)
    (fmt_sel[2:1] == 2'b11) |=> (!smp_valid && left_smp == '0 && right_smp == '0));

  p_pad16_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    (smp_valid && ($past(fmt_sel) == 3'b000 || $past(fmt_sel) == 3'b100))
      |-> (left_smp[7:0] == 8'h00 && right_smp[7:0] == 8'h00));

  p_pad20_r6: assert property (@(posedge bclk) disable iff (!rst_n)
    (smp_valid && $past(fmt_sel) == 3'b001) |-> (left_smp[3:0] == 4'h0 && right_smp[3:0] == 4'h0));

endmodule

bind aud_ser_rx aud_ser_rx_chk #(.SMP_W(SMP_W)) u_chk (
  .bclk      (bclk),
  .rst_n     (rst_n),
  .wclk      (wclk),
  .fmt_sel   (fmt_sel),
  .left_smp  (left_smp),
  .right_smp (right_smp),
  .smp_valid (smp_valid)
);

// File: tb/sim_aud_ser_rx.sv
`timescale 1ns/1ps
module sim_aud_ser_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wclk = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt_sel = 3'b000;
  logic [23:0] left_smp, right_smp;
  logic        smp_valid;

  int checks = 0;
  int errors = 0;

  logic [47:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  aud_ser_rx u0 (
    .bclk      (clk),
    .rst_n     (rst_n),
    .wclk      (wclk),
    .sdata     (sdata),
    .fmt_sel   (fmt_sel),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .smp_valid (smp_valid)
  );

  function automatic logic [23:0] align_word(logic [23:0] w, int wl);
    logic [31:0] m;
    m = (32'h1 << wl) - 32'h1;
    return 24'((32'(w) & m) << (24 - wl));
  endfunction

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected strobe: actual L=%h R=%h expected no strobe", left_smp, right_smp);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({left_smp, right_smp} !== e) begin
          errors++;
          $display("FAIL %s pair: actual L=%h R=%h expected L=%h R=%h", t, left_smp, right_smp, e[47:24], e[23:0]);
        end
      end
    end
  end

  // mode: 0 right-justified, 1 left-justified, 2 I2S
  task automatic drive_half(input logic lvl, input logic [23:0] w, input int wl, input int hl, input int mode);
    for (int i = 0; i < hl; i++) begin
      @(negedge clk);
      wclk  = lvl;
      sdata = 1'($urandom);
      if (mode == 0 && i >= hl - wl) sdata = w[wl - 1 - (i - (hl - wl))];
      if (mode == 1 && i < wl)       sdata = w[wl - 1 - i];
      if (mode == 2 && i >= 1 && i <= wl) sdata = w[wl - i];
    end
  endtask

  task automatic send_frame(input int mode, input int wl, input logic lhi, input logic [23:0] l,
                            input logic [23:0] r, input int hl, input int hr, input string t);
    drive_half(lhi, l, wl, hl, mode);
    drive_half(!lhi, r, wl, hr, mode);
    exp_q.push_back({align_word(l, wl), align_word(r, wl)});
    tag_q.push_back(t);
  endtask

  task automatic check_val(input logic [23:0] act, input logic [23:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic start_run(input logic [2:0] code, input logic idle_lvl);
    @(negedge clk);
    rst_n   = 1'b0;
    fmt_sel = code;
    wclk    = idle_lvl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic flush(input logic lhi);
    drive_half(lhi, 24'h0, 16, 3, 0);
    check_val({23'd0, 1'(exp_q.size())}, 24'd0, "R7 scoreboard drained");
  endtask

  task automatic run_format(input logic [2:0] code, input int mode, input int wl, input logic lhi, input string t);
    int minh;
    minh = (mode == 2) ? wl + 1 : wl;
    start_run(code, !lhi);
    send_frame(mode, wl, lhi, 24'h123456, 24'h6A5C3E, 32, 32, t);
    send_frame(mode, wl, lhi, 24'hFEDCBA, 24'h0F0F0F, minh, minh, t);
    send_frame(mode, wl, lhi, 24'hFFFFFF, 24'h800000 >> (24 - wl), 34, 30, {t, " R9 unequal halves"});
    send_frame(mode, wl, lhi, 24'h000001, 24'h7FFFFF, 30, 34, {t, " R9 unequal halves"});
    flush(lhi);
  endtask

  initial begin
    // R10: reset state
    #1;
    check_val(left_smp, 24'h0, "R10 reset left");
    check_val(right_smp, 24'h0, "R10 reset right");
    check_val({23'd0, smp_valid}, 24'h0, "R10 reset strobe");

    run_format(3'b000, 0, 16, 1'b1, "R2 R1 rj16");
    run_format(3'b001, 0, 20, 1'b1, "R2 R6 rj20");
    run_format(3'b010, 0, 24, 1'b1, "R2 rj24");
    run_format(3'b011, 1, 24, 1'b1, "R3 lj24");
    run_format(3'b100, 2, 16, 1'b0, "R4 R6 i2s16");
    run_format(3'b101, 2, 24, 1'b0, "R4 R5 i2s24");

    // R8: switching a running stream to an invalid code clears the outputs
    start_run(3'b010, 1'b0);
    send_frame(0, 24, 1'b1, 24'hA1B2C3, 24'h4D5E6F, 32, 32, "R8 before switch");
    flush(1'b1);
    check_val(left_smp, 24'hA1B2C3, "R8 value before switch");
    @(negedge clk);
    fmt_sel = 3'b111;
    @(negedge clk);
    check_val(left_smp, 24'h0, "R8 left after switch");
    check_val(right_smp, 24'h0, "R8 right after switch");

    // R8: invalid code from reset, stream must give no strobe
    start_run(3'b110, 1'b0);
    drive_half(1'b1, 24'h55AA55, 24, 32, 0);
    drive_half(1'b0, 24'h33CC33, 24, 32, 0);
    drive_half(1'b1, 24'h55AA55, 24, 32, 0);
    drive_half(1'b0, 24'h33CC33, 24, 32, 0);
    drive_half(1'b1, 24'h0, 24, 4, 0);
    check_val(left_smp, 24'h0, "R8 left stays zero");
    check_val(right_smp, 24'h0, "R8 right stays zero");

    // R10: reset released inside a left half; that half and the next right are discarded
    start_run(3'b010, 1'b1);
    drive_half(1'b1, 24'hDEAD01, 24, 10, 0);
    drive_half(1'b0, 24'hBEEF02, 24, 32, 0);
    send_frame(0, 24, 1'b1, 24'h102030, 24'h405060, 32, 32, "R10 first strobe");
    flush(1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule